// File: doc/BRIEF.md
# Byte-Lane Static RAM Core

This block is a synthesizable behavioural model of a static RAM with 32-bit words split into four byte lanes. It needs no refresh and keeps its contents for as long as it is not written. Two chip selects of opposite polarity pick the device. A write strobe, a read strobe and four active-low lane enables then decide what happens: power-down, selected with nothing driven, a read of chosen lanes, or a write of chosen lanes. The lane enables gate reads as well as writes, and a write always wins over the read strobe.

Inside a clocked FPGA fabric, the asynchronous write cycle is rebuilt from sampled controls. While the write strobe is seen low, the address, data and lane mask are held in a staging register. They are committed to the array on the first clock edge at which the write has ended, either because the strobe rose or because the chip was deselected. The read path is combinational from the controls and the address. A per-lane drive vector stands in for the tri-state pads, and the data lanes that are not driven show Z. A cycle of reads right after a write sees the new data, because the staged write is forwarded. A standby output flags the power-down state, and an active output flags every selected state.

The default address width is kept small for simulation. The full 512K-word configuration is reached by setting `ADDR_W` to 19.

Top module: `byte_lane_sram`

## Requirements
- R1: A word is 32 bits in four lanes. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24. Bit i of `lane_en_n` and bit i of `lane_drive` belong to lane i.
- R2: When `sel_n` is 1 or `sel_hi` is 0, the device is deselected. In that state `lane_drive` is 0000, every `rdata` lane is Z, `standby` is 1 and `active` is 0.
- R3: With `sel_n`=0, `sel_hi`=1, `wr_en_n`=1 and `rd_en_n`=0, the device reads. Lane i is driven with the stored byte exactly when `lane_en_n[i]`=0. The other lanes have `lane_drive[i]`=0 and show Z.
- R4: With both selects asserted and `wr_en_n`=0, the device writes, whatever the level of `rd_en_n`. No lane is driven while it writes.
- R5: During a write phase, the bytes whose `lane_en_n` bit is 0 are captured at each clock edge. The values from the last edge of the phase are stored. The store takes place at the first clock edge at which the controls no longer show a write, which happens when `wr_en_n` rises or the device is deselected. Lanes that are not enabled keep their old contents.
- R6: A read issued in the cycle right after a write phase ends returns the newly written bytes for the lanes that were written.
- R7: With both selects asserted and `rd_en_n`=`wr_en_n`=1, `lane_drive` is 0000, `standby` is 0 and `active` is 1.
- R8: While the device is deselected, `wr_en_n`=0 has no effect, and the stored contents are kept unchanged.
- R9: A synchronous `rst`=1 discards a write that has not yet been committed. It does not alter the array.
- R10: `standby` and `active` follow the controls combinationally. `active` is 1 in the read, write and selected-idle states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the controls |
| rst | input | 1 | Synchronous active-high reset of the write staging |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| rd_en_n | input | 1 | Active-low read strobe |
| wr_en_n | input | 1 | Active-low write strobe |
| lane_en_n | input | 4 | Active-low byte-lane enables |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; lanes that are not driven show Z |
| lane_drive | output | 4 | Per-lane drive flags standing in for tri-state |
| standby | output | 1 | High while deselected |
| active | output | 1 | High in any selected state |

## Verification
The bench builds the core with `ADDR_W`=4, so the array holds 16 words. Every word can be preloaded and tracked in a shadow model, and random traffic hits the same addresses again and again. That reuse brings partial-mask overwrites, the forwarding of a staged write into the next read, and deselected write attempts onto live data within reach of a short run.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mode_t;
endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic  sel_n,
  input  logic  sel_hi,
  input  logic  rd_en_n,
  input  logic  wr_en_n,
  output mode_t mode,
  output logic  standby,
  output logic  active
);
  // Deselect wins over everything, then the write strobe outranks the read strobe.
  always_comb begin
    if (sel_n || !sel_hi)  mode = MODE_STBY;
    else if (!wr_en_n)     mode = MODE_WRITE;
    else if (!rd_en_n)     mode = MODE_READ;
    else                   mode = MODE_IDLE;
  end

  assign standby = (mode == MODE_STBY);
  assign active  = (mode == MODE_IDLE) || (mode == MODE_READ) || (mode == MODE_WRITE);
endmodule

// File: rtl/bls_write_hold.sv
module bls_write_hold #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_en_n,
  output logic                    cm_valid,
  output logic [ADDR_W-1:0]       cm_addr,
  output logic [LANES*LANE_W-1:0] cm_data,
  output logic [LANES-1:0]        cm_mask
);
  logic pend_v;

  // Staging register: the last sampled write of a phase wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
    end else if (wr_mode) begin
      pend_v <= 1'b1;
    end else begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_mode) begin
      cm_addr <= addr;
      cm_data <= wdata;
      cm_mask <= ~lane_en_n;
    end
  end

  // Commit on the first cycle after the write phase has ended.
  assign cm_valid = pend_v && !wr_mode && !rst;

  AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> pend_v); // R5
  AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (rst)
    cm_valid |=> !cm_valid); // R5
  AST_RESET_DROPS: assert property (@(posedge clk)
    rst |=> !pend_v); // R9
endmodule

// File: rtl/bls_array.sv
module bls_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // One narrow memory per lane keeps each byte write a plain RAM write port.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[l]) begin
        mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      end
    end

    assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];

    AST_BYTE_STORED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mask[l]) |=> (mem[$past(wr_addr)] == $past(wr_data[l*LANE_W +: LANE_W]))); // R5
  end
endmodule

// File: rtl/bls_read_lanes.sv
module bls_read_lanes
  import bls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  mode_t                   mode,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_data,
  input  logic                    cm_valid,
  input  logic [ADDR_W-1:0]       cm_addr,
  input  logic [LANES*LANE_W-1:0] cm_data,
  input  logic [LANES-1:0]        cm_mask,
  output logic [LANES-1:0]        lane_drive,
  output logic [LANES*LANE_W-1:0] lane_data
);
  logic addr_hit;
  assign addr_hit = cm_valid && (cm_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // A byte still in flight to the array is forwarded to the reader.
    assign lane_data[l*LANE_W +: LANE_W] = (addr_hit && cm_mask[l])
                                           ? cm_data[l*LANE_W +: LANE_W]
                                           : arr_data[l*LANE_W +: LANE_W];
    assign lane_drive[l] = (mode == MODE_READ) && !lane_en_n[l];
  end
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel_n,
  input  logic                       sel_hi,
  input  logic                       rd_en_n,
  input  logic                       wr_en_n,
  input  logic [LANES-1:0]           lane_en_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES*LANE_W-1:0]    wdata,
  output logic [LANES*LANE_W-1:0]    rdata,
  output logic [LANES-1:0]           lane_drive,
  output logic                       standby,
  output logic                       active
);
  localparam int DATA_W = LANES * LANE_W;

  mode_t               mode;
  logic                cm_valid;
  logic [ADDR_W-1:0]   cm_addr;
  logic [DATA_W-1:0]   cm_data;
  logic [LANES-1:0]    cm_mask;
  logic [DATA_W-1:0]   arr_data;
  logic [DATA_W-1:0]   lane_data;

  bls_decode i_decode (
    .sel_n   (sel_n),
    .sel_hi  (sel_hi),
    .rd_en_n (rd_en_n),
    .wr_en_n (wr_en_n),
    .mode    (mode),
    .standby (standby),
    .active  (active)
  );

  bls_write_hold #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_mode   (mode == MODE_WRITE),
    .addr      (addr),
    .wdata     (wdata),
    .lane_en_n (lane_en_n),
    .cm_valid  (cm_valid),
    .cm_addr   (cm_addr),
    .cm_data   (cm_data),
    .cm_mask   (cm_mask)
  );

  bls_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cm_valid),
    .wr_addr (cm_addr),
    .wr_data (cm_data),
    .wr_mask (cm_mask),
    .rd_addr (addr),
    .rd_data (arr_data)
  );

  bls_read_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_read (
    .mode       (mode),
    .lane_en_n  (lane_en_n),
    .rd_addr    (addr),
    .arr_data   (arr_data),
    .cm_valid   (cm_valid),
    .cm_addr    (cm_addr),
    .cm_data    (cm_data),
    .cm_mask    (cm_mask),
    .lane_drive (lane_drive),
    .lane_data  (lane_data)
  );

  // Lane i covers bits [8i+7:8i]; undriven lanes float.
  for (genvar l = 0; l < LANES; l++) begin : g_pad
    assign rdata[l*LANE_W +: LANE_W] = lane_drive[l] ? lane_data[l*LANE_W +: LANE_W]
                                                     : {LANE_W{1'bz}};
  end

  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    standby |-> (lane_drive == '0)); // R2
  AST_READ_LANES: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel_hi && wr_en_n && !rd_en_n) |-> (lane_drive == ~lane_en_n)); // R3
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel_hi && !wr_en_n) |-> (lane_drive == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (active && rd_en_n) |-> (lane_drive == '0)); // R7
  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({standby, active}) == 1); // R10
  AST_STBY_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    ($past(standby) && standby) |-> !cm_valid); // R8
endmodule

// File: tb/test_byte_lane_sram.sv
module test_byte_lane_sram;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, sel_hi = 1'b0, rd_en_n = 1'b1, wr_en_n = 1'b1;
  logic [3:0]    lane_en_n = 4'hf;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [3:0]    lane_drive;
  logic          standby, active;

  int errors = 0;
  int checks = 0;
  logic [31:0] refm [NW];

  always #10 clk = ~clk;

  byte_lane_sram #(.ADDR_W(AW), .LANES(4)) i_byte_lane_sram (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel_hi(sel_hi), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_drive(lane_drive), .standby(standby), .active(active)
  );

  // op: 0 write, 1 read, 2 write attempt with sel_n high, 3 write attempt with sel_hi low
  localparam logic [41:0] VEC [12] = '{
    {2'd0, 4'd1,  4'b0000, 32'hA1B2C3D4},   // R5 full word
    {2'd1, 4'd1,  4'b0000, 32'h0},          // R3 all lanes
    {2'd0, 4'd1,  4'b1110, 32'h000000EE},   // R1 lane 0 = bits 7:0 only
    {2'd1, 4'd1,  4'b0000, 32'h0},
    {2'd0, 4'd2,  4'b0111, 32'h7F000000},   // R1 lane 3 = bits 31:24 only
    {2'd1, 4'd2,  4'b0110, 32'h0},          // R3 lanes 0 and 3
    {2'd2, 4'd1,  4'b0000, 32'hDEADBEEF},   // R8
    {2'd1, 4'd1,  4'b1001, 32'h0},          // R3 middle lanes
    {2'd3, 4'd2,  4'b0000, 32'h55555555},   // R8
    {2'd1, 4'd2,  4'b0000, 32'h0},
    {2'd0, 4'd15, 4'b1010, 32'h12345678},   // R1 lanes 0 and 2
    {2'd1, 4'd15, 4'b0101, 32'h0}           // R3 lanes 1 and 3
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic s_n, input logic s_hi, input logic r_n, input logic w_n);
    sel_n = s_n; sel_hi = s_hi; rd_en_n = r_n; wr_en_n = w_n;
  endtask

  task automatic upd_ref(input int a, input logic [31:0] d, input logic [3:0] bwn);
    for (int l = 0; l < 4; l++)
      if (!bwn[l]) refm[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  // One write cycle, then one selected-idle cycle in which the commit happens.
  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] bwn, input logic rdn);
    @(negedge clk);
    set_ctl(1'b0, 1'b1, rdn, 1'b0); addr = a[AW-1:0]; wdata = d; lane_en_n = bwn;
    #2 chk(lane_drive == 4'h0, "R4 no drive while writing", {28'h0, lane_drive}, 32'h0);
    @(negedge clk);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1); lane_en_n = 4'hf;
    upd_ref(a, d, bwn);
  endtask

  task automatic do_read(input int a, input logic [3:0] bwn, input string req);
    @(negedge clk);
    set_ctl(1'b0, 1'b1, 1'b0, 1'b1); addr = a[AW-1:0]; lane_en_n = bwn;
    #2 chk(lane_drive == ~bwn, {req, " lane drive"}, {28'h0, lane_drive}, {28'h0, ~bwn});
    for (int l = 0; l < 4; l++)
      if (!bwn[l]) chk(rdata[l*8 +: 8] == refm[a][l*8 +: 8], {req, " lane data"},
                       {24'h0, rdata[l*8 +: 8]}, {24'h0, refm[a][l*8 +: 8]});
  endtask

  task automatic desel_write(input int a, input logic [31:0] d, input bit via_hi);
    @(negedge clk);
    if (via_hi) set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    else        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    addr = a[AW-1:0]; wdata = d; lane_en_n = 4'h0;
    #2 chk(standby && !active && lane_drive == 4'h0, "R2 deselected state",
           {26'h0, standby, active, lane_drive}, 32'h20);
    @(negedge clk);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1); lane_en_n = 4'hf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Reset state: deselected controls.
    repeat (3) @(negedge clk);
    chk(standby == 1'b1 && active == 1'b0, "R2 R10 reset standby", {30'h0, standby, active}, 32'h2);
    chk(lane_drive == 4'h0, "R2 reset no drive", {28'h0, lane_drive}, 32'h0);
    rst = 1'b0;

    for (int a = 0; a < NW; a++) do_write(a, 32'h01010101 * (a + 1), 4'h0, 1'b1);
    for (int a = 0; a < NW; a++) do_read(a, 4'h0, "R5 preload");

    foreach (VEC[i]) begin
      case (VEC[i][41:40])
        2'd0: do_write(int'(VEC[i][39:36]), VEC[i][31:0], VEC[i][35:32], 1'b1);
        2'd1: do_read(int'(VEC[i][39:36]), VEC[i][35:32], "R3 table read");
        2'd2: desel_write(int'(VEC[i][39:36]), VEC[i][31:0], 1'b0);
        default: desel_write(int'(VEC[i][39:36]), VEC[i][31:0], 1'b1);
      endcase
    end

    // R7 selected idle
    @(negedge clk); set_ctl(1'b0, 1'b1, 1'b1, 1'b1); lane_en_n = 4'h0;
    #2 chk(lane_drive == 4'h0 && active && !standby, "R7 selected idle",
           {26'h0, standby, active, lane_drive}, 32'h10);

    // R4 write wins over the read strobe
    do_write(5, 32'hCAFEF00D, 4'h0, 1'b0);
    do_read(5, 4'h0, "R4 write with read strobe low");

    // R6 forwarding: read in the commit cycle
    @(negedge clk); set_ctl(1'b0, 1'b1, 1'b1, 1'b0); addr = 4'd7; wdata = 32'h9988AA77; lane_en_n = 4'b1100;
    @(negedge clk); set_ctl(1'b0, 1'b1, 1'b0, 1'b1); lane_en_n = 4'h0;
    upd_ref(7, 32'h9988AA77, 4'b1100);
    #2 chk(rdata == refm[7], "R6 forwarded read", rdata, refm[7]);

    // R5 last sample of a phase wins, phase ended by deselection
    @(negedge clk); set_ctl(1'b0, 1'b1, 1'b1, 1'b0); addr = 4'd9; wdata = 32'h11111111; lane_en_n = 4'h0;
    @(negedge clk); wdata = 32'h22222222;
    @(negedge clk); set_ctl(1'b1, 1'b1, 1'b1, 1'b1); lane_en_n = 4'hf;
    upd_ref(9, 32'h22222222, 4'h0);
    do_read(9, 4'h0, "R5 last sample, ended by deselect");

    // R9 reset drops a staged write
    @(negedge clk); set_ctl(1'b0, 1'b1, 1'b1, 1'b0); addr = 4'd11; wdata = 32'hBADBAD00; lane_en_n = 4'h0;
    @(negedge clk); rst = 1'b1; set_ctl(1'b0, 1'b1, 1'b1, 1'b1); lane_en_n = 4'hf;
    @(negedge clk); rst = 1'b0;
    do_read(11, 4'h0, "R9 staged write discarded");

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      int a = int'($urandom_range(0, NW - 1));
      if ($urandom_range(0, 2) == 0)
        desel_write(a, $urandom, $urandom_range(0, 1) == 1);
      else
        do_write(a, $urandom, 4'($urandom), 1'($urandom));
      do_read(int'($urandom_range(0, NW - 1)), 4'($urandom), "R3 R5 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule